// File: doc/BRIEF.md
# Dual-Mode 3x3 Matrix and Convolution Engine

This block is a pipelined arithmetic core with nine signed multipliers. The same multipliers serve two jobs. In matrix mode each sample carries the three 10-bit components of one pixel. The block returns three results for that sample, and each result weights all three components by one row of a 3x3 coefficient set. This is the usual way to convert between colour spaces or to correct colour sensitivity. In convolution mode each sample is one column of three vertically adjacent pixels. The block keeps the three most recent columns and weights the 3x3 window by the same nine coefficients. It returns their total on the first output lane, which suits sharpening, smoothing and edge filters.

The mode input picks the job. Operand multiplexers in front of the multipliers decide which stored pixel reaches which multiplier. Coefficients are loaded through a small write port. Every arithmetic value is signed two's complement. A valid flag moves through all six register stages together with the data, so in matrix mode a continuous input stream gives one output set on every clock. When the mode changes, the work still in flight is discarded and the window starts empty.

Top module: `mxc_engine`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, all three outputs are 0, and all nine coefficients are 0.
- R2: In matrix mode (`mode`=0), for an accepted sample with components x0=`in_c0`, x1=`in_c1`, x2=`in_c2`, output lane i equals the sum over j of k[3i+j]·xj. Here k[n] is the coefficient at address n, and all values are signed.
- R3: A sample with `in_valid`=1 that is presented before the rising edge E produces its result, with `out_valid`=1, directly after the fifth edge following E. That is six register stages. In matrix mode every accepted sample gives one result, and a cycle without `in_valid` gives an output cycle with `out_valid`=0.
- R4: In convolution mode (`mode`=1) a column enters the window only when `in_valid`=1. No result is flagged valid until three columns have entered since reset or since the last mode change.
- R5: In convolution mode the result on lane 0 is the sum over r and c of k[3r+c]·P(r,c). Column c=0 is the oldest of the three columns held and c=2 is the newest. Row r of a column is the pixel given on `in_c<r>`.
- R6: In convolution mode, lanes 1 and 2 are 0 whenever `out_valid`=1.
- R7: Each output saturates to the signed 20-bit range [-524288, 524287] instead of wrapping.
- R8: With `cf_we`=1 and `cf_addr` in 0..8, coefficient `cf_addr` takes `cf_wdata`. A sample presented in the same cycle as the write already uses the new value.
- R9: A write with `cf_addr` in 9..15 changes no coefficient.
- R10: In the cycle where `mode` differs from its value in the previous cycle, the results of all samples accepted in the five cycles before are discarded (they never show `out_valid`=1), and the column window is emptied. The sample presented in that cycle belongs to the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 1 | 0 = matrix mode, 1 = convolution mode |
| in_valid | input | 1 | A sample is present this cycle |
| in_c0 | input | 10 | Component 0, or window row 0 (signed) |
| in_c1 | input | 10 | Component 1, or window row 1 (signed) |
| in_c2 | input | 10 | Component 2, or window row 2 (signed) |
| cf_we | input | 1 | Coefficient write strobe |
| cf_addr | input | 4 | Coefficient index, 0..8 valid |
| cf_wdata | input | 10 | Coefficient value (signed) |
| out_valid | output | 1 | Output lanes hold a result |
| out_y0 | output | 20 | Lane 0 result (signed, saturated) |
| out_y1 | output | 20 | Lane 1 result (signed, saturated) |
| out_y2 | output | 20 | Lane 2 result (signed, saturated) |

## Verification
Two pairs of events can land in the same cycle. A coefficient write can arrive in the same cycle as the sample that should already use it. A mode change can arrive in the same cycle as a sample that must open the new mode. The bench drives the first pair during coefficient loading, where each write comes with a live matrix-mode sample. It drives the second pair by switching mode in the middle of a stream, including a convolution burst that lasts only one column. A reference model in the bench applies the write before it computes the result and marks the five samples still in flight as lost. Each output cycle is then compared with the model six cycles after its sample.

// File: rtl/mxc_pkg.sv
// Package mxc_pkg
// Holds the types and constants shared by the dual-mode engine.
// Assumes a fixed 3x3 geometry; data widths are parameters of the modules.
package mxc_pkg;

    // Side length of the coefficient matrix and of the convolution window.
    localparam int N  = 3;
    // Number of coefficients and multipliers.
    localparam int NK = N * N;

    // Operating mode selected at the block's edge.
    typedef enum logic {
        MODE_MATRIX = 1'b0,
        MODE_CONV   = 1'b1
    } mxc_mode_e;

endpackage

// File: rtl/mxc_coef_bank.sv
// Module mxc_coef_bank
// Nine signed coefficient registers with a single write port.
// Assumes addresses at or above NK are simply not decoded.
module mxc_coef_bank
    import mxc_pkg::*;
#(
    parameter int CW = 10,
    parameter int AW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [CW-1:0] wr_data,
    output logic signed [CW-1:0] coef [NK]
);

    logic signed [CW-1:0] coef_q [NK];

    for (genvar k = 0; k < NK; k++) begin : g_reg
        // Load one coefficient when its index is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                coef_q[k] <= '0;
            end else if (wr_en && wr_addr == AW'(k)) begin
                coef_q[k] <= wr_data;
            end
        end

        assign coef[k] = coef_q[k];

        // R8: an addressed write lands in the register.
        a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == AW'(k)) |=> (coef_q[k] == $past(wr_data)));

        // R9: a register not addressed keeps its value.
        a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en || wr_addr != AW'(k)) |=> $stable(coef_q[k]));
    end

endmodule

// File: rtl/mxc_window.sv
// Module mxc_window
// Input stage: captures each sample and keeps a column shift register
// for the convolution window. It steers the operands of the nine
// multipliers by mode. It assumes flush is high in the cycle in which
// the mode differs from the previous cycle.
module mxc_window
    import mxc_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  mxc_mode_e            mode,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_px [N],
    output logic                 win_vld,
    output mxc_mode_e            win_mode,
    output logic signed [DW-1:0] opnd [NK]
);

    localparam int FW = $clog2(N + 1);

    // col_q[s][r]: stage s (0 = newest column), row r.
    logic signed [DW-1:0] col_q [N][N];
    logic [FW-1:0]        fill_q, fill_base, fill_nx;
    logic                 vld_q;
    mxc_mode_e            mode_q;

    // Column count after this cycle's shift, restarted by a flush.
    always_comb begin
        fill_base = flush ? '0 : fill_q;
        fill_nx   = fill_base;
        if (mode == MODE_CONV && in_valid && fill_base != FW'(N)) begin
            fill_nx = fill_base + 1'b1;
        end else if (mode == MODE_MATRIX) begin
            fill_nx = '0;
        end
    end

    // Capture the sample and shift older columns in convolution mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < N; s++) begin
                for (int r = 0; r < N; r++) begin
                    col_q[s][r] <= '0;
                end
            end
        end else begin
            for (int r = 0; r < N; r++) begin
                if (in_valid) begin
                    col_q[0][r] <= in_px[r];
                end else if (flush) begin
                    col_q[0][r] <= '0;
                end
                for (int s = 1; s < N; s++) begin
                    if (in_valid && mode == MODE_CONV) begin
                        col_q[s][r] <= flush ? '0 : col_q[s-1][r];
                    end else if (flush) begin
                        col_q[s][r] <= '0;
                    end
                end
            end
        end
    end

    // Track the fill level, the stage valid flag and the stage mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            vld_q  <= 1'b0;
            mode_q <= MODE_MATRIX;
        end else begin
            fill_q <= fill_nx;
            vld_q  <= in_valid && (mode == MODE_MATRIX || fill_nx == FW'(N));
            mode_q <= mode;
        end
    end

    // Route the pixel for row r, column c to multiplier r*N+c.
    always_comb begin
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                opnd[r*N + c] = (mode_q == MODE_MATRIX) ? col_q[0][c]
                                                        : col_q[N-1-c][r];
            end
        end
    end

    assign win_vld  = vld_q;
    assign win_mode = mode_q;

    // R3: a matrix-mode sample is always accepted.
    a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_MATRIX) |=> vld_q);

    // R4: a convolution result needs a full window.
    a_r4_full: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && mode_q == MODE_CONV) |-> (fill_q == FW'(N)));

    // R10: a mode change with no sample empties the window.
    a_r10_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && mode == MODE_CONV && !in_valid) |=> (fill_q == '0));

endmodule

// File: rtl/mxc_mul_array.sv
// Module mxc_mul_array
// Nine registered signed multipliers: product k is operand k times
// coefficient k. A flush clears the stage valid flag.
module mxc_mul_array
    import mxc_pkg::*;
#(
    parameter int DW = 10,
    parameter int CW = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          in_vld,
    input  mxc_mode_e                     in_mode,
    input  logic signed [DW-1:0]          opnd [NK],
    input  logic signed [CW-1:0]          coef [NK],
    output logic                          prod_vld,
    output mxc_mode_e                     prod_mode,
    output logic signed [DW+CW-1:0]       prod [NK]
);

    localparam int PW = DW + CW;

    logic signed [PW-1:0] prod_q [NK];
    logic                 vld_q;
    mxc_mode_e            mode_q;

    for (genvar k = 0; k < NK; k++) begin : g_mul
        // Register one full-precision signed product.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prod_q[k] <= '0;
            end else begin
                prod_q[k] <= PW'(opnd[k]) * PW'(coef[k]);
            end
        end
        assign prod[k] = prod_q[k];
    end

    // Carry the valid flag and mode along with the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            mode_q <= MODE_MATRIX;
        end else begin
            vld_q  <= in_vld && !flush;
            mode_q <= in_mode;
        end
    end

    assign prod_vld  = vld_q;
    assign prod_mode = mode_q;

    // R10: a mode change kills the work in this stage.
    a_r10_kill: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !vld_q);

endmodule

// File: rtl/mxc_sum_tree.sv
// Module mxc_sum_tree
// Four register stages: pair sums per lane, lane sums, a mode-dependent
// final add, and the saturating output register. Assumes N = 3, so each
// lane holds one pair and one single product.
module mxc_sum_tree
    import mxc_pkg::*;
#(
    parameter int PW = 20,
    parameter int OW = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  in_vld,
    input  mxc_mode_e             in_mode,
    input  logic signed [PW-1:0]  prod [NK],
    output logic                  out_vld,
    output logic signed [OW-1:0]  y [N]
);

    localparam int P1 = PW + 1;
    localparam int P2 = PW + 2;
    localparam int SW = PW + 4;
    localparam logic signed [SW-1:0] YMAX = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [SW-1:0] YMIN = {{(SW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    logic signed [P1-1:0] pair_q [N];
    logic signed [PW-1:0] solo_q [N];
    logic signed [P2-1:0] lane_q [N];
    logic signed [SW-1:0] fin_d  [N];
    logic signed [SW-1:0] fin_q  [N];
    logic signed [OW-1:0] y_q    [N];
    logic                 vld_a, vld_b, vld_c, vld_o;
    mxc_mode_e            mode_a, mode_b;

    // Level 1: add the first two products of each lane, keep the third.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                pair_q[i] <= '0;
                solo_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                pair_q[i] <= P1'(prod[i*N]) + P1'(prod[i*N + 1]);
                solo_q[i] <= prod[i*N + 2];
            end
        end
    end

    // Level 2: complete each lane sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                lane_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                lane_q[i] <= P2'(pair_q[i]) + P2'(solo_q[i]);
            end
        end
    end

    // Final add: separate lanes in matrix mode, one total in convolution mode.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            fin_d[i] = '0;
        end
        if (mode_b == MODE_MATRIX) begin
            for (int i = 0; i < N; i++) begin
                fin_d[i] = SW'(lane_q[i]);
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                fin_d[0] = fin_d[0] + SW'(lane_q[i]);
            end
        end
    end

    // Register the final sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                fin_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                fin_q[i] <= fin_d[i];
            end
        end
    end

    // Output register: clamp each lane into the signed output range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                y_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (fin_q[i] > YMAX) begin
                    y_q[i] <= YMAX[OW-1:0];
                end else if (fin_q[i] < YMIN) begin
                    y_q[i] <= YMIN[OW-1:0];
                end else begin
                    y_q[i] <= fin_q[i][OW-1:0];
                end
            end
        end
    end

    // Move the valid flag and mode through the four stages, clearing on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_a  <= 1'b0;
            vld_b  <= 1'b0;
            vld_c  <= 1'b0;
            vld_o  <= 1'b0;
            mode_a <= MODE_MATRIX;
            mode_b <= MODE_MATRIX;
        end else begin
            vld_a  <= in_vld && !flush;
            vld_b  <= vld_a && !flush;
            vld_c  <= vld_b && !flush;
            vld_o  <= vld_c && !flush;
            mode_a <= in_mode;
            mode_b <= mode_a;
        end
    end

    assign out_vld = vld_o;
    for (genvar i = 0; i < N; i++) begin : g_out
        assign y[i] = y_q[i];
    end

    // R10: a mode change leaves nothing valid at the output on the next cycle.
    a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !vld_o);

endmodule

// File: rtl/mxc_engine.sv
// Module mxc_engine (top)
// Dual-mode 3x3 engine: per-pixel colour matrixing or a sliding 3x3
// convolution over columns, sharing nine multipliers. The pipeline has six
// register stages. A change of mode flushes the work in flight and empties
// the window. Assumes the coefficient addresses 0..8 fit in AW bits.
module mxc_engine
    import mxc_pkg::*;
#(
    parameter int DW = 10,
    parameter int CW = 10,
    parameter int OW = 20,
    parameter int AW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_c0,
    input  logic signed [DW-1:0] in_c1,
    input  logic signed [DW-1:0] in_c2,
    input  logic                 cf_we,
    input  logic [AW-1:0]        cf_addr,
    input  logic signed [CW-1:0] cf_wdata,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_y0,
    output logic signed [OW-1:0] out_y1,
    output logic signed [OW-1:0] out_y2
);

    localparam int PW = DW + CW;

    mxc_mode_e            mode_e, mode_q;
    logic                 flush;
    logic signed [DW-1:0] px   [N];
    logic signed [CW-1:0] coef [NK];
    logic signed [DW-1:0] opnd [NK];
    logic signed [PW-1:0] prod [NK];
    logic signed [OW-1:0] y    [N];
    logic                 win_vld, prod_vld;
    mxc_mode_e            win_mode, prod_mode;

    assign mode_e = mxc_mode_e'(mode);
    assign px[0]  = in_c0;
    assign px[1]  = in_c1;
    assign px[2]  = in_c2;

    // Remember the previous mode so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_MATRIX;
        end else begin
            mode_q <= mode_e;
        end
    end

    assign flush = (mode_e != mode_q);

    mxc_coef_bank #(.CW(CW), .AW(AW)) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cf_we),
        .wr_addr (cf_addr),
        .wr_data (cf_wdata),
        .coef    (coef)
    );

    mxc_window #(.DW(DW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .mode     (mode_e),
        .in_valid (in_valid),
        .in_px    (px),
        .win_vld  (win_vld),
        .win_mode (win_mode),
        .opnd     (opnd)
    );

    mxc_mul_array #(.DW(DW), .CW(CW)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .in_vld    (win_vld),
        .in_mode   (win_mode),
        .opnd      (opnd),
        .coef      (coef),
        .prod_vld  (prod_vld),
        .prod_mode (prod_mode),
        .prod      (prod)
    );

    mxc_sum_tree #(.PW(PW), .OW(OW)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .in_vld  (prod_vld),
        .in_mode (prod_mode),
        .prod    (prod),
        .out_vld (out_valid),
        .y       (y)
    );

    assign out_y0 = y[0];
    assign out_y1 = y[1];
    assign out_y2 = y[2];

    // R3: every valid output traces back to a sample six edges earlier.
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 6));

endmodule

// File: tb/tb_mxc_engine.sv
`timescale 1ns/1ps
module tb_mxc_engine;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               mode;
    logic               in_valid;
    logic signed [9:0]  in_c0, in_c1, in_c2;
    logic               cf_we;
    logic [3:0]         cf_addr;
    logic signed [9:0]  cf_wdata;
    logic               out_valid;
    logic signed [19:0] out_y0, out_y1, out_y2;

    mxc_engine dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
        .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .cf_we(cf_we), .cf_addr(cf_addr), .cf_wdata(cf_wdata),
        .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2)
    );

    always #10 clk = ~clk;

    // Stimulus table: mode, in_valid, c0, c1, c2.
    localparam int NV = 15;
    localparam int VEC [NV][5] = '{
        '{0, 1,    1,    2,   3},
        '{0, 1,   -5,    4, 100},
        '{0, 0,    9,    9,   9},
        '{0, 1,  511, -512,   0},
        '{0, 1,   -1,   -1,  -1},
        '{0, 1,  200, -300,  77},
        '{1, 1,    1,    2,   3},
        '{1, 1,    4,    5,   6},
        '{1, 0,    0,    0,   0},
        '{1, 1,    7,    8,   9},
        '{1, 1,  -10,   20, -30},
        '{1, 1,  100, -200, 300},
        '{1, 0,    1,    1,   1},
        '{1, 1,  511,  511, 511},
        '{1, 1, -512,    0,  50}
    };
    localparam int KV [9] = '{3, -2, 1, 0, 5, -1, 7, 2, -4};

    int    n_chk = 0, n_fail = 0, cyc = 0;
    bit    done = 0;
    string ph;
    int    m_k [9];
    int    m_col [3][3];
    int    m_fill, m_prev;
    bit    e_v [64];
    int    e_y [64][3];
    string e_tag [64];
    string e_t12 [64];

    task automatic chk(input int act, input int exp, input string tag, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int sat20(input int v);
        if (v > 524287) return 524287;
        if (v < -524288) return -524288;
        return v;
    endfunction

    // One cycle: compare outputs with the model, drive inputs, update the model.
    task automatic step(input int md, input int vl, input int a, input int b, input int c,
                        input int we, input int wa, input int wd);
        int slot, acc;
        int px [3];
        @(negedge clk);
        slot = (cyc + 58) & 63;
        chk(int'(out_valid), int'(e_v[slot]), e_tag[slot], "out_valid");
        if (e_v[slot]) begin
            chk(int'(out_y0), e_y[slot][0], e_tag[slot], "out_y0");
            chk(int'(out_y1), e_y[slot][1], e_t12[slot], "out_y1");
            chk(int'(out_y2), e_y[slot][2], e_t12[slot], "out_y2");
        end
        mode = md[0]; in_valid = vl[0];
        in_c0 = 10'(a); in_c1 = 10'(b); in_c2 = 10'(c);
        cf_we = we[0]; cf_addr = 4'(wa); cf_wdata = 10'(wd);
        px[0] = a; px[1] = b; px[2] = c;
        if (we != 0 && wa < 9) m_k[wa] = wd;
        if (md != m_prev) begin
            for (int d = 1; d <= 5; d++) begin
                e_v[(cyc + 64 - d) & 63]   = 1'b0;
                e_tag[(cyc + 64 - d) & 63] = "R10";
            end
            for (int s = 0; s < 3; s++)
                for (int r = 0; r < 3; r++) m_col[s][r] = 0;
            m_fill = 0;
        end
        m_prev = md;
        slot = cyc & 63;
        e_y[slot][0] = 0; e_y[slot][1] = 0; e_y[slot][2] = 0;
        e_t12[slot] = ph;
        if (md == 0) begin
            m_fill = 0;
            e_v[slot]   = (vl != 0);
            e_tag[slot] = (vl != 0) ? ph : "R3";
            for (int i = 0; i < 3; i++) begin
                acc = 0;
                for (int j = 0; j < 3; j++) acc += m_k[3*i + j] * px[j];
                e_y[slot][i] = sat20(acc);
            end
        end else begin
            if (vl != 0) begin
                for (int s = 2; s > 0; s--)
                    for (int r = 0; r < 3; r++) m_col[s][r] = m_col[s-1][r];
                for (int r = 0; r < 3; r++) m_col[0][r] = px[r];
                if (m_fill < 3) m_fill++;
            end
            e_v[slot]   = (vl != 0) && (m_fill == 3);
            e_tag[slot] = e_v[slot] ? "R5" : "R4";
            e_t12[slot] = "R6";
            acc = 0;
            for (int r = 0; r < 3; r++)
                for (int cc = 0; cc < 3; cc++) acc += m_k[3*r + cc] * m_col[2 - cc][r];
            e_y[slot][0] = sat20(acc);
        end
        cyc++;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode = 1'b0; in_valid = 1'b0;
        in_c0 = '0; in_c1 = '0; in_c2 = '0;
        cf_we = 1'b0; cf_addr = '0; cf_wdata = '0;
        for (int i = 0; i < 9; i++) m_k[i] = 0;
        for (int s = 0; s < 3; s++)
            for (int r = 0; r < 3; r++) m_col[s][r] = 0;
        m_fill = 0; m_prev = 0;
        for (int i = 0; i < 64; i++) begin
            e_v[i] = 1'b0; e_tag[i] = "R1"; e_t12[i] = "R1";
            e_y[i][0] = 0; e_y[i][1] = 0; e_y[i][2] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports.
        chk(int'(out_valid), 0, "R1", "out_valid after reset");
        chk(int'(out_y0), 0, "R1", "out_y0 after reset");
        chk(int'(out_y1), 0, "R1", "out_y1 after reset");
        chk(int'(out_y2), 0, "R1", "out_y2 after reset");

        // R1: coefficients start at zero, so results are zero.
        ph = "R1";
        step(0, 1, 10, 20, 30, 0, 0, 0);
        step(0, 1, -7, 300, -1, 0, 0, 0);

        // R8: each write comes with a sample that must already use it.
        ph = "R8";
        for (int k = 0; k < 9; k++) step(0, 1, k + 1, -(k + 2), 2 * k, 1, k, KV[k]);

        // R9: writes to unused addresses are ignored.
        ph = "R9";
        for (int a = 9; a < 16; a++) step(0, 1, 50, -60, 70, 1, a, 511);

        // R2/R3: matrix-mode rows of the table.
        ph = "R2";
        for (int v = 0; v < 6; v++) step(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0, 0, 0);

        // R7: drive lanes 0 and 1 past both saturation limits.
        ph = "R7";
        for (int k = 0; k < 3; k++) step(0, 1, -512, -512, -512, 1, k, -512);
        for (int k = 3; k < 6; k++) step(0, 1, -512, -512, -512, 1, k, 511);
        step(0, 1, -512, -512, -512, 0, 0, 0);
        step(0, 1, 511, 511, 511, 0, 0, 0);
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0, 1, k, KV[k]);

        // R4/R5/R6: convolution rows of the table.
        ph = "R5";
        for (int v = 6; v < NV; v++) step(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0, 0, 0);

        // R10: mode changes in the middle of a stream.
        ph = "R10";
        step(0, 1, 3, 3, 3, 0, 0, 0);
        step(0, 1, 4, -4, 4, 0, 0, 0);
        step(1, 1, 1, 1, 1, 0, 0, 0);
        step(0, 1, 5, 6, 7, 0, 0, 0);
        step(1, 1, 2, 2, 2, 0, 0, 0);
        step(1, 1, 3, -3, 3, 0, 0, 0);
        step(1, 1, 9, 8, 7, 0, 0, 0);
        step(1, 1, -6, 5, -4, 0, 0, 0);
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule